// File: doc/BRIEF.md
# Pileup density estimator

The block estimates the average pileup energy density (rho) seen by one calorimeter trigger region during a frame. Towers arrive one per cycle. Each carries an eta index, a tower identifier and two energies in MeV, one electromagnetic and one hadronic. Every energy is first truncated to the coarse count granularity that the downstream firmware uses. It then passes through a programmable acceptance window. Accepted energies are accumulated, with a tower count, in one of five regions: the electromagnetic layer, three hadronic eta bands, and the forward region.

A frame opens with a start pulse, which clears the accumulators, and closes with a tower flagged as last. One cycle after that tower is accumulated, each region's average is formed. The average is a multiplication by a reciprocal taken from a count-indexed table, followed by a right shift, so no divider is needed. The results are presented for one cycle with a valid strobe. They come in two forms: the raw internal-count values, which a later subtraction stage consumes, and copies scaled back to MeV. The outputs hold their values until the next frame completes. The window thresholds come from configuration registers outside the block and must not change while a frame is in progress.

Top module: `pu_rho_estimator`

## Requirements
- R1: The coarse electromagnetic energy is floor(em_et_i / 25). The coarse hadronic energy is floor(had_et_i / 500) when tower_eta_i < 15, and floor(had_et_i / 25) otherwise.
- R2: A coarse energy counts towards a region only when it is strictly greater than that layer's low threshold and strictly less than its high threshold. A rejected energy changes neither the region's sum nor its count.
- R3: Towers with tower_eta_i below 32 feed region 0 (electromagnetic) through the electromagnetic window. Towers with tower_eta_i of 32 or more feed only region 4 (forward), through the forward window. For forward towers, the hadronic coarse energy is used when tower_id_i >= 1024 and the electromagnetic coarse energy otherwise.
- R4: The hadronic coarse energy of a tower with tower_eta_i below 32 goes through the hadronic window into exactly one band: region 1 for eta < 15, region 2 for eta == 15, region 3 for eta 16 to 31.
- R5: Each region's rho is (sum × T[min(count, 64)]) >> 12, where T[n] = round(4096 / n) with halves rounded up. The result on rho_o slice r belongs to region r.
- R6: A region that accepted no tower during the frame reports rho 0 and MeV rho 0.
- R7: rho_mev_o slice 1 equals rho of region 1 × 500. Every other slice equals its region's rho × 25.
- R8: frame_start_i clears all sums and counts. A tower presented in the same cycle as frame_start_i is the first tower of the new frame. A start pulse with no tower still clears.
- R9: rho_valid_o is high for exactly one cycle, two rising edges after the edge that captures the tower flagged last. rho_o and rho_mev_o update together with it and hold until the next valid. After reset, rho_valid_o is low and every rho output reads 0.
- R10: A region count above 64 uses the table entry for 64 (T[64] = 64).
- R11: Sums and counts do not wrap for frames of up to 256 towers at full-scale input energy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start_i | input | 1 | Clears all region accumulators |
| tower_valid_i | input | 1 | A tower is presented this cycle |
| tower_last_i | input | 1 | The presented tower closes the frame |
| tower_eta_i | input | 6 | Tower eta index |
| tower_id_i | input | 12 | Tower identifier (selects the forward layer) |
| em_et_i | input | 16 | Electromagnetic energy, MeV |
| had_et_i | input | 16 | Hadronic energy, MeV |
| thr_em_lo_i | input | 16 | Electromagnetic window low bound, coarse counts |
| thr_em_hi_i | input | 16 | Electromagnetic window high bound, coarse counts |
| thr_had_lo_i | input | 16 | Hadronic window low bound, coarse counts |
| thr_had_hi_i | input | 16 | Hadronic window high bound, coarse counts |
| thr_fwd_lo_i | input | 16 | Forward window low bound, coarse counts |
| thr_fwd_hi_i | input | 16 | Forward window high bound, coarse counts |
| rho_valid_o | output | 1 | One-cycle strobe: new rho values |
| rho_o | output | 5×25 | Rho per region, internal counts |
| rho_mev_o | output | 5×34 | Rho per region, scaled to MeV |

## Verification
A corrupted sum or count shows up only once per frame, in the rho values that come out two edges after the last tower. A wrong truncation, a window edge that is off by one, or a misrouted band therefore appears at the next valid strobe as a mismatch in a single region's slice, while the other slices stay correct. A stale accumulator that survives a start pulse contaminates the frame that follows. The scenarios therefore run frames back to back, use start pulses without a tower, put counts past the table end, and retune the windows between frames, so that every such fault reaches a compared valid within a few cycles.

// File: rtl/pu_rho_pkg.sv
// Shared constants and helpers for the pileup density estimator.
// Assumes five regions in fixed order: EM, hadronic bands low/mid/high, forward.
package pu_rho_pkg;
    localparam int N_REG      = 5;
    localparam int RG_EM      = 0;
    localparam int RG_HAD_LO  = 1;
    localparam int RG_HAD_MID = 2;
    localparam int RG_HAD_HI  = 3;
    localparam int RG_FWD     = 4;

    // Rounded reciprocal 2^shift / n, halves rounded up; zero for n == 0.
    function automatic int unsigned recip_round(input int unsigned n, input int unsigned shift);
        if (n == 0) return 0;
        return ((32'd1 << (shift + 1)) + n) / (2 * n);
    endfunction
endpackage

// File: rtl/pu_tower_sort.sv
// Converts one tower's MeV energies to coarse counts, applies the per-layer
// windows and decides which regions the tower feeds this cycle.
// Assumes thresholds are stable while a frame is in progress.
module pu_tower_sort
    import pu_rho_pkg::*;
#(
    parameter int E_W              = 16,
    parameter int ETA_W            = 6,
    parameter int ID_W             = 12,
    parameter int ETA_HAD_SPLIT    = 15,
    parameter int ETA_FWD_START    = 32,
    parameter int FWD_HAD_ID_START = 1024,
    parameter int GRAN_FINE        = 25,
    parameter int GRAN_COARSE      = 500
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ETA_W-1:0]            eta_i,
    input  logic [ID_W-1:0]             id_i,
    input  logic [E_W-1:0]              em_i,
    input  logic [E_W-1:0]              had_i,
    input  logic [E_W-1:0]              em_lo_i,
    input  logic [E_W-1:0]              em_hi_i,
    input  logic [E_W-1:0]              had_lo_i,
    input  logic [E_W-1:0]              had_hi_i,
    input  logic [E_W-1:0]              fwd_lo_i,
    input  logic [E_W-1:0]              fwd_hi_i,
    output logic [N_REG-1:0]            hit_o,
    output logic [N_REG-1:0][E_W-1:0]   val_o
);
    localparam logic [E_W-1:0]   DIV_FINE   = E_W'(GRAN_FINE);
    localparam logic [E_W-1:0]   DIV_COARSE = E_W'(GRAN_COARSE);
    localparam logic [ETA_W-1:0] ETA_SPLIT  = ETA_W'(ETA_HAD_SPLIT);
    localparam logic [ETA_W-1:0] ETA_FWD    = ETA_W'(ETA_FWD_START);
    localparam logic [ID_W-1:0]  ID_FWD_HAD = ID_W'(FWD_HAD_ID_START);

    logic [E_W-1:0] em_c, had_c, fwd_c;
    logic           in_em, in_had, in_fwd, is_fwd;

    // Granularity conversion, window tests and region routing for one tower.
    always_comb begin
        em_c   = em_i / DIV_FINE;
        had_c  = (eta_i < ETA_SPLIT) ? (had_i / DIV_COARSE) : (had_i / DIV_FINE);
        fwd_c  = (id_i >= ID_FWD_HAD) ? had_c : em_c;
        is_fwd = (eta_i >= ETA_FWD);
        in_em  = (em_c  > em_lo_i)  && (em_c  < em_hi_i);
        in_had = (had_c > had_lo_i) && (had_c < had_hi_i);
        in_fwd = (fwd_c > fwd_lo_i) && (fwd_c < fwd_hi_i);
        hit_o[RG_EM]      = !is_fwd && in_em;
        hit_o[RG_HAD_LO]  = (eta_i <  ETA_SPLIT) && in_had;
        hit_o[RG_HAD_MID] = (eta_i == ETA_SPLIT) && in_had;
        hit_o[RG_HAD_HI]  = (eta_i >  ETA_SPLIT) && !is_fwd && in_had;
        hit_o[RG_FWD]     = is_fwd && in_fwd;
        val_o[RG_EM]      = em_c;
        val_o[RG_HAD_LO]  = had_c;
        val_o[RG_HAD_MID] = had_c;
        val_o[RG_HAD_HI]  = had_c;
        val_o[RG_FWD]     = fwd_c;
    end

    // R4: a tower never lands in two hadronic bands.
    assert_one_band_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_o[RG_HAD_HI:RG_HAD_LO]));
    // R3: a forward tower feeds no central region.
    assert_fwd_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o[RG_FWD] |-> (hit_o[RG_HAD_HI:RG_EM] == '0));
endmodule

// File: rtl/pu_region_acc.sv
// Sum and count of accepted coarse energies for one region.
// Assumes at most MAX_TOWERS towers per frame; widths are sized for that.
module pu_region_acc #(
    parameter int E_W   = 16,
    parameter int CNT_W = 9,
    parameter int SUM_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             add_i,
    input  logic [E_W-1:0]   val_i,
    output logic [SUM_W-1:0] sum_o,
    output logic [CNT_W-1:0] cnt_o
);
    // Clear on frame start (keeping a same-cycle tower), else accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_o <= '0;
            cnt_o <= '0;
        end else if (clear_i) begin
            sum_o <= add_i ? SUM_W'(val_i) : '0;
            cnt_o <= add_i ? CNT_W'(1) : '0;
        end else if (add_i) begin
            sum_o <= sum_o + SUM_W'(val_i);
            cnt_o <= cnt_o + CNT_W'(1);
        end
    end

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i && !add_i |=> (cnt_o == '0) && (sum_o == '0));
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        add_i && !clear_i |=> cnt_o == $past(cnt_o) + CNT_W'(1));
    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (sum_o >= $past(sum_o)) && (cnt_o >= $past(cnt_o)));
endmodule

// File: rtl/pu_rho_avg.sv
// Averages one region: sum times a rounded reciprocal of the count, shifted,
// then scaled to MeV by the region's granularity. Registers on load_i.
// Assumes CNT_W can hold N_MAX; larger counts use the last table entry.
module pu_rho_avg
    import pu_rho_pkg::*;
#(
    parameter int SUM_W     = 25,
    parameter int CNT_W     = 9,
    parameter int N_MAX     = 64,
    parameter int RHO_SHIFT = 12,
    parameter int RHO_W     = 25,
    parameter int MEV_W     = 34,
    parameter int SCALE     = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [SUM_W-1:0] sum_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [RHO_W-1:0] rho_o,
    output logic [MEV_W-1:0] mev_o
);
    localparam int LUT_W = RHO_SHIFT + 1;
    localparam int IDX_W = $clog2(N_MAX + 1);
    localparam int PRD_W = SUM_W + LUT_W;

    logic [LUT_W-1:0] lut [N_MAX+1];
    for (genvar n = 0; n <= N_MAX; n++) begin : g_lut
        assign lut[n] = LUT_W'(recip_round(n, RHO_SHIFT));
    end

    logic [IDX_W-1:0] idx;
    logic [PRD_W-1:0] prod;
    logic [RHO_W-1:0] rho_n;
    logic [MEV_W-1:0] mev_n;

    // Table index with saturation, reciprocal multiply, shift and MeV scaling.
    always_comb begin
        idx   = (cnt_i > CNT_W'(N_MAX)) ? IDX_W'(N_MAX) : IDX_W'(cnt_i);
        prod  = PRD_W'(sum_i) * PRD_W'(lut[idx]);
        rho_n = (cnt_i == '0) ? '0 : RHO_W'(prod >> RHO_SHIFT);
        mev_n = MEV_W'(rho_n) * MEV_W'(SCALE);
    end

    // Capture the averaged values at the end of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rho_o <= '0;
            mev_o <= '0;
        end else if (load_i) begin
            rho_o <= rho_n;
            mev_o <= mev_n;
        end
    end

    assert_rho_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> RHO_W'(rho_o) <= RHO_W'($past(sum_i)));
    assert_zero_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && (cnt_i == '0) |=> (rho_o == '0) && (mev_o == '0));
endmodule

// File: rtl/pu_rho_estimator.sv
// Top of the pileup density estimator: routes streamed towers into five
// region accumulators and, one cycle after the last tower, averages each.
// Assumes frame_start_i opens every frame and thresholds hold during a frame.
module pu_rho_estimator
    import pu_rho_pkg::*;
#(
    parameter int E_W              = 16,
    parameter int ETA_W            = 6,
    parameter int ID_W             = 12,
    parameter int MAX_TOWERS       = 256,
    parameter int N_MAX            = 64,
    parameter int RHO_SHIFT        = 12,
    parameter int ETA_HAD_SPLIT    = 15,
    parameter int ETA_FWD_START    = 32,
    parameter int FWD_HAD_ID_START = 1024,
    parameter int GRAN_FINE        = 25,
    parameter int GRAN_COARSE      = 500,
    localparam int CNT_W = $clog2(MAX_TOWERS + 1),
    localparam int SUM_W = E_W + CNT_W,
    localparam int RHO_W = SUM_W,
    localparam int MEV_W = RHO_W + $clog2(GRAN_COARSE + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          frame_start_i,
    input  logic                          tower_valid_i,
    input  logic                          tower_last_i,
    input  logic [ETA_W-1:0]              tower_eta_i,
    input  logic [ID_W-1:0]               tower_id_i,
    input  logic [E_W-1:0]                em_et_i,
    input  logic [E_W-1:0]                had_et_i,
    input  logic [E_W-1:0]                thr_em_lo_i,
    input  logic [E_W-1:0]                thr_em_hi_i,
    input  logic [E_W-1:0]                thr_had_lo_i,
    input  logic [E_W-1:0]                thr_had_hi_i,
    input  logic [E_W-1:0]                thr_fwd_lo_i,
    input  logic [E_W-1:0]                thr_fwd_hi_i,
    output logic                          rho_valid_o,
    output logic [N_REG-1:0][RHO_W-1:0]   rho_o,
    output logic [N_REG-1:0][MEV_W-1:0]   rho_mev_o
);
    logic [N_REG-1:0]          hit;
    logic [N_REG-1:0][E_W-1:0] val;
    logic                      done_q;

    pu_tower_sort #(
        .E_W(E_W), .ETA_W(ETA_W), .ID_W(ID_W),
        .ETA_HAD_SPLIT(ETA_HAD_SPLIT), .ETA_FWD_START(ETA_FWD_START),
        .FWD_HAD_ID_START(FWD_HAD_ID_START),
        .GRAN_FINE(GRAN_FINE), .GRAN_COARSE(GRAN_COARSE)
    ) u_sort (
        .clk(clk), .rst_n(rst_n),
        .eta_i(tower_eta_i), .id_i(tower_id_i),
        .em_i(em_et_i), .had_i(had_et_i),
        .em_lo_i(thr_em_lo_i), .em_hi_i(thr_em_hi_i),
        .had_lo_i(thr_had_lo_i), .had_hi_i(thr_had_hi_i),
        .fwd_lo_i(thr_fwd_lo_i), .fwd_hi_i(thr_fwd_hi_i),
        .hit_o(hit), .val_o(val)
    );

    for (genvar r = 0; r < N_REG; r++) begin : g_region
        logic [SUM_W-1:0] sum;
        logic [CNT_W-1:0] cnt;

        pu_region_acc #(.E_W(E_W), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_acc (
            .clk(clk), .rst_n(rst_n),
            .clear_i(frame_start_i),
            .add_i(tower_valid_i && hit[r]),
            .val_i(val[r]),
            .sum_o(sum), .cnt_o(cnt)
        );

        pu_rho_avg #(
            .SUM_W(SUM_W), .CNT_W(CNT_W), .N_MAX(N_MAX), .RHO_SHIFT(RHO_SHIFT),
            .RHO_W(RHO_W), .MEV_W(MEV_W),
            .SCALE((r == RG_HAD_LO) ? GRAN_COARSE : GRAN_FINE)
        ) u_avg (
            .clk(clk), .rst_n(rst_n),
            .load_i(done_q),
            .sum_i(sum), .cnt_i(cnt),
            .rho_o(rho_o[r]), .mev_o(rho_mev_o[r])
        );
    end

    // Frame-end sequencing: mark the last tower, then strobe valid with the load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q      <= 1'b0;
            rho_valid_o <= 1'b0;
        end else begin
            done_q      <= tower_valid_i && tower_last_i;
            rho_valid_o <= done_q;
        end
    end

    assert_valid_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tower_valid_i && tower_last_i |=> ##1 rho_valid_o);
endmodule

// File: tb/sim_pu_rho_estimator.sv
module sim_pu_rho_estimator;
    localparam int CLK_PERIOD = 10;
    localparam int E_W = 16, ETA_W = 6, ID_W = 12;
    localparam int N_MAX = 64, RHO_SHIFT = 12, FWD_ID = 1024;
    localparam int RHO_W = 25, MEV_W = 34;

    logic clk = 1'b0, rst_n = 1'b0;
    logic frame_start = 1'b0, tvalid = 1'b0, tlast = 1'b0;
    logic [ETA_W-1:0] eta = '0;
    logic [ID_W-1:0]  id = '0;
    logic [E_W-1:0]   em = '0, had = '0;
    logic [E_W-1:0]   em_lo = 16'd2, em_hi = 16'd200;
    logic [E_W-1:0]   had_lo = 16'd1, had_hi = 16'd100;
    logic [E_W-1:0]   fwd_lo = 16'd3, fwd_hi = 16'd150;
    logic             rho_valid;
    logic [4:0][RHO_W-1:0] rho;
    logic [4:0][MEV_W-1:0] mev;

    pu_rho_estimator u0 (
        .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start),
        .tower_valid_i(tvalid), .tower_last_i(tlast),
        .tower_eta_i(eta), .tower_id_i(id), .em_et_i(em), .had_et_i(had),
        .thr_em_lo_i(em_lo), .thr_em_hi_i(em_hi),
        .thr_had_lo_i(had_lo), .thr_had_hi_i(had_hi),
        .thr_fwd_lo_i(fwd_lo), .thr_fwd_hi_i(fwd_hi),
        .rho_valid_o(rho_valid), .rho_o(rho), .rho_mev_o(mev)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct packed { logic [4:0][47:0] rho; logic [31:0] due; } exp_t;
    exp_t   sb_q[$];
    exp_t   last_exp;
    longint m_sum[5], m_cnt[5];
    int     n_chk = 0, n_bad = 0;
    string  scen = "reset";

    function automatic longint lutv(longint n);
        return ((64'd1 << (RHO_SHIFT + 1)) + n) / (2 * n);
    endfunction

    // R5, R6, R10 model of one region's average
    function automatic longint rho_of(longint s, longint c);
        longint lc;
        if (c == 0) return 0;
        lc = (c > N_MAX) ? N_MAX : c;
        return (s * lutv(lc)) >> RHO_SHIFT;
    endfunction

    task automatic check(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s [%s] %s: actual %0d expected %0d", req, scen, what, act, exp);
        end
    endtask

    // Driver: model the tower (R1-R4, R8), present it, push expectation on last.
    task automatic tower(int e, int i, int em_v, int had_v, bit st, bit ls);
        longint emc, hadc, fv;
        int b;
        exp_t x;
        if (st) for (int r = 0; r < 5; r++) begin m_sum[r] = 0; m_cnt[r] = 0; end
        emc  = em_v / 25;
        hadc = (e < 15) ? had_v / 500 : had_v / 25;
        if (e < 32) begin
            if (emc > longint'(em_lo) && emc < longint'(em_hi)) begin m_sum[0] += emc; m_cnt[0]++; end
            b = (e < 15) ? 1 : ((e == 15) ? 2 : 3);
            if (hadc > longint'(had_lo) && hadc < longint'(had_hi)) begin m_sum[b] += hadc; m_cnt[b]++; end
        end else begin
            fv = (i >= FWD_ID) ? hadc : emc;
            if (fv > longint'(fwd_lo) && fv < longint'(fwd_hi)) begin m_sum[4] += fv; m_cnt[4]++; end
        end
        eta = ETA_W'(e); id = ID_W'(i); em = E_W'(em_v); had = E_W'(had_v);
        frame_start = st; tvalid = 1'b1; tlast = ls;
        @(posedge clk); #1;
        if (ls) begin
            for (int r = 0; r < 5; r++) x.rho[r] = 48'(rho_of(m_sum[r], m_cnt[r]));
            x.due = 32'(cyc + 1);
            sb_q.push_back(x);
        end
        frame_start = 1'b0; tvalid = 1'b0; tlast = 1'b0;
    endtask

    task automatic start_only();
        for (int r = 0; r < 5; r++) begin m_sum[r] = 0; m_cnt[r] = 0; end
        frame_start = 1'b1;
        @(posedge clk); #1;
        frame_start = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    // Monitor: pop and compare at each valid strobe (R5, R7, R9).
    always @(negedge clk) begin
        if (rst_n && rho_valid) begin
            if (sb_q.size() == 0) check("R9", "valid without a closed frame", 1, 0);
            else begin
                exp_t e;
                e = sb_q.pop_front();
                last_exp = e;
                check("R9", "valid cycle", cyc, longint'(e.due));
                for (int r = 0; r < 5; r++) begin
                    check("R5", $sformatf("rho region %0d", r), longint'(rho[r]), longint'(e.rho[r]));
                    check("R7", $sformatf("MeV rho region %0d", r), longint'(mev[r]),
                          longint'(e.rho[r]) * ((r == 1) ? 500 : 25));
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check("R9", "watchdog expired", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int r = 0; r < 5; r++) begin m_sum[r] = 0; m_cnt[r] = 0; end
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "reset valid", rho_valid, 0);
        for (int r = 0; r < 5; r++) check("R9", "reset rho", longint'(rho[r]), 0);
        @(posedge clk); #1;

        // R1 R2 R3 R4: truncation, window edges, band and forward routing
        scen = "R1 R2 R3 R4 mixed";
        tower(3, 10, 2500, 5000, 1, 0);
        tower(3, 11, 74, 499, 0, 0);
        tower(15, 20, 5024, 2475, 0, 0);
        tower(15, 21, 1000, 1000, 0, 0);
        tower(20, 30, 25, 750, 0, 0);
        tower(31, 31, 4999, 24, 0, 0);
        tower(14, 40, 0, 1499, 0, 0);
        tower(32, 100, 1250, 5000, 0, 0);
        tower(40, 1500, 2000, 1000, 0, 0);
        tower(33, 1100, 500, 75, 0, 1);
        idle(3);

        // R6: single-tower frame, start and last together, other regions empty
        scen = "R6 empty regions";
        tower(5, 1, 1000, 0, 1, 1);
        // R8: next frame starts on the very next cycle
        scen = "R8 back-to-back";
        tower(16, 2, 0, 500, 1, 0);
        tower(16, 3, 0, 2000, 0, 1);
        idle(3);

        // R8: a start pulse alone clears, tower without start follows
        scen = "R8 start without tower";
        tower(5, 1, 3000, 3000, 1, 0);
        start_only();
        tower(20, 4, 400, 400, 0, 1);
        idle(3);

        // R10: more than 64 accepted towers in one region
        scen = "R10 count saturation";
        for (int k = 0; k < 70; k++) tower(5, k, 2500, 0, (k == 0), 0);
        tower(35, 50, 500, 0, 0, 1);
        idle(3);

        // R2: narrow window after retune, both bounds excluded
        scen = "R2 retuned window";
        em_lo = 16'd99; em_hi = 16'd101;
        tower(8, 1, 2500, 0, 1, 0);
        tower(8, 2, 2475, 0, 0, 0);
        tower(8, 3, 2525, 0, 0, 1);
        idle(4);

        // R9: outputs hold after the strobe
        scen = "R9 hold";
        check("R9", "valid low while idle", rho_valid, 0);
        for (int r = 0; r < 5; r++)
            check("R9", "rho held", longint'(rho[r]), longint'(last_exp.rho[r]));
        check("R9", "all expectations consumed", sb_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule